// File: doc/BRIEF.md
# Interrupt IN Endpoint Transmit Buffer

This block is the transmit half of one USB device endpoint that serves interrupt IN transfers. On the CPU side it takes a byte stream into a packet store, and a commit strobe publishes what has been written as one packet. Committing with no bytes written publishes a zero-length packet. On the serial-engine side it accepts IN tokens and handshake outcomes. For each token it answers with a response header (PID and length), followed by the payload as a byte stream. NRZI coding, bit stuffing and CRC are left to the engine.

Two interrupt flavours are decoded from two configuration pins. In normal mode a packet leaves the store only when the host acknowledges it. A timeout keeps it for a retry under the same PID, and an optional second slot lets the CPU fill one packet while the other waits. In rate-feedback mode only one packet is ever queued, whatever the double-buffer pin says. That packet is returned for every token until the CPU commits a replacement. The data toggle still advances on each acknowledged transmission in both modes.

Both streams use valid/ready. The CPU byte stream stalls only while the store is full (`wr_ready` low). Bytes offered then are not taken and the CPU must hold them. The payload stream holds `tx_data` and `tx_last` steady while `tx_ready` is low, and advances one byte per cycle in which both `tx_valid` and `tx_ready` are high. `tx_ready` may be held low for any number of cycles.

Top module: `usb_intin_ep`

## Requirements
- R1: After reset no packet is queued. The toggle selects DATA0, `wr_ready`=1, `buf_full`=0, `ovf`=0, `rsp_valid`=0 and `tx_valid`=0.
- R2: The mode is decoded from the two configuration pins. `cfg_iso`=0 with `cfg_intr`=0 selects normal mode, and `cfg_iso`=0 with `cfg_intr`=1 selects rate-feedback mode. With `cfg_iso`=1 the endpoint is inactive and answers every IN token with NAK, even when a packet is committed.
- R3: An IN token arriving while no packet is queued gives, one cycle later, a single-cycle `rsp_valid` with `rsp_pid`=4'b1010 (NAK), `rsp_len`=0 and no payload.
- R4: An IN token arriving while a packet is queued gives, one cycle later, `rsp_valid` with `rsp_pid` 4'b0011 (DATA0) or 4'b1011 (DATA1) and the packet length. The payload bytes follow in write order on the valid/ready stream, starting in that same cycle, with `tx_last` on the final byte. A stalled byte is held unchanged.
- R5: A commit with no bytes written queues a zero-length packet. The answer to a token carries `rsp_len`=0 and `tx_valid` never rises.
- R6: In normal mode, `hs_ack` releases the packet and flips the toggle. `hs_tmo` keeps the packet and the PID for the next token.
- R7: In normal mode with double buffering off, one committed packet makes `buf_full`=1 and `wr_ready`=0. Writes and commits offered while full are ignored.
- R8: In normal mode with `cfg_dbl`=1, two packets can be queued and are sent in commit order. `buf_full` rises only when both are committed.
- R9: Rate-feedback mode queues a single packet regardless of `cfg_dbl`, and repeats it (with a flipping toggle on each ACK) for every token. A new commit replaces it from the next idle cycle onward. `buf_full` is high only between such a commit and its taking effect.
- R10: A one-cycle `tgl_clr` pulse makes the next data response use DATA0.
- R11: Bytes written past `MAXP` (default 64) are dropped and set the sticky `ovf` flag. The packet length saturates at `MAXP`.
- R12: A token arriving while a transaction is still in progress is ignored and produces no response. A handshake arriving while no transaction awaits one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_iso | input | 1 | Isochronous-type select (1 = endpoint inactive here) |
| cfg_intr | input | 1 | Interrupt flavour: 0 normal, 1 rate feedback |
| cfg_dbl | input | 1 | Double-buffer enable (normal mode only) |
| tgl_clr | input | 1 | Pulse: next data PID is DATA0 |
| wr_valid | input | 1 | CPU byte offered |
| wr_ready | output | 1 | Store can take a byte |
| wr_data | input | 8 | CPU byte |
| commit | input | 1 | Pulse: publish written bytes as a packet |
| buf_full | output | 1 | No room for another packet |
| ovf | output | 1 | Sticky: bytes dropped past MAXP |
| tok_in | input | 1 | Pulse: IN token for this endpoint |
| hs_ack | input | 1 | Pulse: host acknowledged |
| hs_tmo | input | 1 | Pulse: no handshake before timeout |
| rsp_valid | output | 1 | Response header valid (one cycle) |
| rsp_pid | output | 4 | Response PID |
| rsp_len | output | LW | Payload length in bytes |
| tx_valid | output | 1 | Payload byte valid |
| tx_ready | input | 1 | Engine takes the payload byte |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final payload byte |

## Verification
The bench targets the points where a packet must survive. It sends a timeout followed by a retry, and a stray ACK with nothing outstanding. Either would either lose a packet or skip a toggle value in a design that releases too early. It fills both slots in double-buffer mode to catch a design that sends out of order or reports full after the first commit. In rate-feedback mode it sends repeated tokens across ACKs and a later replacement. A design that drained the slot would NAK there, and one that froze the toggle would repeat DATA0. Zero-length packets, a write burst past the size limit, tokens arriving mid-transfer and payload stalls round it out, catching spurious bytes, a wrapped write pointer, a doubled response and a byte that changes while stalled.

// File: rtl/usb_intin_pkg.sv
package usb_intin_pkg;
  typedef enum logic [1:0] {EP_NORMAL, EP_RATEFB, EP_OFF} ep_mode_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam int         NSLOT     = 2;
endpackage

// File: rtl/intin_pktmem.sv
module intin_pktmem #(
  parameter int MAXP = 64,
  localparam int AW = $clog2(MAXP)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wslot,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rslot,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] rd_bank [usb_intin_pkg::NSLOT];

  for (genvar s = 0; s < usb_intin_pkg::NSLOT; s++) begin : g_bank
    logic [7:0] bank [MAXP];
    always_ff @(posedge clk) begin
      if (we && (wslot == s[0])) bank[waddr] <= wdata;
    end
    assign rd_bank[s] = bank[raddr];
  end

  assign rdata = rd_bank[rslot];
endmodule

// File: rtl/intin_bufmgr.sv
module intin_bufmgr
  import usb_intin_pkg::*;
#(
  parameter int MAXP = 64,
  localparam int LW = $clog2(MAXP + 1),
  localparam int AW = $clog2(MAXP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ep_mode_e      mode,
  input  logic          dbl_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          commit,
  output logic          full,
  output logic          ovf,
  output logic          mem_we,
  output logic          mem_wslot,
  output logic [AW-1:0] mem_waddr,
  input  logic          seq_free,
  input  logic          acked,
  output logic          avail,
  output logic          tx_sel,
  output logic [LW-1:0] tx_len
);
  logic [LW-1:0] wr_ptr;
  logic [LW-1:0] len_q [NSLOT];
  logic [1:0]    cnt;
  logic          fill_sel, swap_pend, ovf_q;
  logic          two_slots, wr_fire, room, commit_ok, rel;

  assign two_slots = (mode == EP_NORMAL) && dbl_en;
  assign full      = (mode == EP_RATEFB) ? swap_pend
                                         : (cnt == (two_slots ? 2'd2 : 2'd1));
  assign wr_ready  = !full;
  assign wr_fire   = wr_valid && wr_ready;
  assign room      = wr_ptr < LW'(MAXP);
  assign commit_ok = commit && !full;
  assign rel       = acked && (mode != EP_RATEFB);

  assign mem_we    = wr_fire && room && !commit_ok;
  assign mem_wslot = fill_sel;
  assign mem_waddr = wr_ptr[AW-1:0];
  assign avail     = cnt != 2'd0;
  assign tx_len    = len_q[tx_sel];
  assign ovf       = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      fill_sel  <= 1'b0;
      tx_sel    <= 1'b0;
      cnt       <= 2'd0;
      swap_pend <= 1'b0;
      ovf_q     <= 1'b0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
    end else begin
      if (wr_fire && !room) ovf_q <= 1'b1;
      if (commit_ok) begin
        wr_ptr          <= '0;
        len_q[fill_sel] <= wr_ptr;
      end else if (mem_we) begin
        wr_ptr <= wr_ptr + LW'(1);
      end
      if (mode == EP_RATEFB) begin
        if (commit_ok) begin
          swap_pend <= 1'b1;
        end else if (swap_pend && seq_free) begin
          tx_sel    <= fill_sel;
          fill_sel  <= ~fill_sel;
          cnt       <= 2'd1;
          swap_pend <= 1'b0;
        end
      end else begin
        if (commit_ok) fill_sel <= ~fill_sel;
        if (rel) tx_sel <= ~tx_sel;
        cnt <= cnt + {1'b0, commit_ok} - {1'b0, rel};
      end
    end
  end

  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2); // R8
  AST_RATEFB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EP_RATEFB) |-> cnt <= 2'd1); // R9
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) wr_ptr <= LW'(MAXP)); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q); // R11
  AST_NO_WRITE_TO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && avail) |-> (mem_wslot != tx_sel)); // R8
endmodule

// File: rtl/intin_txseq.sv
module intin_txseq
  import usb_intin_pkg::*;
#(
  parameter int MAXP = 64,
  localparam int LW = $clog2(MAXP + 1),
  localparam int AW = $clog2(MAXP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ep_mode_e      mode,
  input  logic          tok_in,
  input  logic          hs_ack,
  input  logic          hs_tmo,
  input  logic          tgl_clr,
  input  logic          avail,
  input  logic [LW-1:0] tx_len,
  output logic [AW-1:0] rd_addr,
  output logic          seq_free,
  output logic          acked,
  output logic          rsp_valid,
  output logic [3:0]    rsp_pid,
  output logic [LW-1:0] rsp_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last
);
  tx_state_e     state;
  logic [LW-1:0] rd_ptr, len_q;
  logic          toggle;

  assign tx_valid = state == TX_SEND;
  assign tx_last  = tx_valid && (rd_ptr == len_q - LW'(1));
  assign rd_addr  = rd_ptr[AW-1:0];
  assign seq_free = (state == TX_IDLE) && !tok_in;
  assign acked    = (state == TX_WAIT) && hs_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      rd_ptr    <= '0;
      len_q     <= '0;
      toggle    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_pid   <= PID_NAK;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        TX_IDLE: if (tok_in) begin
          rsp_valid <= 1'b1;
          rd_ptr    <= '0;
          if (avail && (mode != EP_OFF)) begin
            rsp_pid <= toggle ? PID_DATA1 : PID_DATA0;
            rsp_len <= tx_len;
            len_q   <= tx_len;
            state   <= (tx_len == '0) ? TX_WAIT : TX_SEND;
          end else begin
            rsp_pid <= PID_NAK;
            rsp_len <= '0;
          end
        end
        TX_SEND: if (tx_ready) begin
          rd_ptr <= rd_ptr + LW'(1);
          if (tx_last) state <= TX_WAIT;
        end
        TX_WAIT: if (hs_ack || hs_tmo) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
      if (tgl_clr) toggle <= 1'b0;
      else if (acked) toggle <= ~toggle;
    end
  end

  AST_NAK_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE && tok_in && !avail) |=> (rsp_valid && rsp_pid == PID_NAK)); // R3
  AST_ZLP_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pid != PID_NAK && rsp_len == '0) |-> !tx_valid); // R5
  AST_BUSY_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state != TX_IDLE && tok_in) |=> !rsp_valid); // R12
endmodule

// File: rtl/usb_intin_ep.sv
module usb_intin_ep
  import usb_intin_pkg::*;
#(
  parameter int MAXP = 64,
  localparam int LW = $clog2(MAXP + 1),
  localparam int AW = $clog2(MAXP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_iso,
  input  logic          cfg_intr,
  input  logic          cfg_dbl,
  input  logic          tgl_clr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  output logic          buf_full,
  output logic          ovf,
  input  logic          tok_in,
  input  logic          hs_ack,
  input  logic          hs_tmo,
  output logic          rsp_valid,
  output logic [3:0]    rsp_pid,
  output logic [LW-1:0] rsp_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  ep_mode_e      mode;
  logic          mem_we, mem_wslot, seq_free, acked, avail, tx_sel;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [LW-1:0] tx_len;

  assign mode = cfg_iso ? EP_OFF : (cfg_intr ? EP_RATEFB : EP_NORMAL);

  intin_bufmgr #(.MAXP(MAXP)) u_bufmgr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl_en(cfg_dbl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .commit(commit),
    .full(buf_full), .ovf(ovf), .mem_we(mem_we), .mem_wslot(mem_wslot),
    .mem_waddr(mem_waddr), .seq_free(seq_free), .acked(acked),
    .avail(avail), .tx_sel(tx_sel), .tx_len(tx_len)
  );

  intin_pktmem #(.MAXP(MAXP)) u_pktmem (
    .clk(clk), .we(mem_we), .wslot(mem_wslot), .waddr(mem_waddr),
    .wdata(wr_data), .rslot(tx_sel), .raddr(rd_addr), .rdata(tx_data)
  );

  intin_txseq #(.MAXP(MAXP)) u_txseq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tok_in(tok_in),
    .hs_ack(hs_ack), .hs_tmo(hs_tmo), .tgl_clr(tgl_clr), .avail(avail),
    .tx_len(tx_len), .rd_addr(rd_addr), .seq_free(seq_free), .acked(acked),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_len(rsp_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !wr_ready); // R7
endmodule

// File: tb/test_usb_intin_ep.sv
`timescale 1ns/1ps
module test_usb_intin_ep;
  localparam int MAXP = 64;
  localparam int LW = $clog2(MAXP + 1);
  localparam logic [3:0] D0 = 4'b0011, D1 = 4'b1011, NAK = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_iso = 0, cfg_intr = 0, cfg_dbl = 0, tgl_clr = 0;
  logic wr_valid = 0, commit = 0, tok_in = 0, hs_ack = 0, hs_tmo = 0, tx_ready = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, buf_full, ovf, rsp_valid, tx_valid, tx_last;
  logic [3:0] rsp_pid;
  logic [LW-1:0] rsp_len;
  logic [7:0] tx_data;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  usb_intin_ep #(.MAXP(MAXP)) i_usb_intin_ep (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_intr(cfg_intr),
    .cfg_dbl(cfg_dbl), .tgl_clr(tgl_clr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .commit(commit),
    .buf_full(buf_full), .ovf(ovf), .tok_in(tok_in), .hs_ack(hs_ack),
    .hs_tmo(hs_tmo), .rsp_valid(rsp_valid), .rsp_pid(rsp_pid),
    .rsp_len(rsp_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic iso, input logic intr, input logic dbl);
    @(negedge clk);
    rst_n = 0; cfg_iso = iso; cfg_intr = intr; cfg_dbl = dbl;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) put_byte(8'((base + i) & 'hff));
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); hs_ack = 1;
    @(negedge clk); hs_ack = 0;
  endtask

  task automatic pulse_tmo();
    @(negedge clk); hs_tmo = 1;
    @(negedge clk); hs_tmo = 0;
  endtask

  task automatic token(input logic [3:0] pid, input int len, input string tag);
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    chk_eq({tag, " rsp_valid"}, rsp_valid, 1);
    chk_eq({tag, " pid"}, rsp_pid, pid);
    chk_eq({tag, " len"}, rsp_len, len);
  endtask

  task automatic recv(input int n, input int base, input bit stall, input string tag);
    int idx = 0;
    int guard = 0;
    while (idx < n && guard < 400) begin
      tx_ready = stall ? guard[0] : 1'b1;
      if (tx_valid && tx_ready) begin
        chk_eq({tag, " data"}, tx_data, (base + idx) & 'hff);
        chk_eq({tag, " last"}, tx_last, (idx == n - 1) ? 1 : 0);
        idx++;
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 0;
    chk_eq({tag, " count"}, idx, n);
    chk_eq({tag, " stream done"}, tx_valid, 0);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0);
    chk_eq("R1 wr_ready", wr_ready, 1);
    chk_eq("R1 buf_full", buf_full, 0);
    chk_eq("R1 ovf", ovf, 0);
    chk_eq("R1 rsp_valid", rsp_valid, 0);
    chk_eq("R1 tx_valid", tx_valid, 0);
    token(NAK, 0, "R1 empty after reset");
  endtask

  task automatic t_nak_empty();
    do_reset(0, 0, 0);
    token(NAK, 0, "R3 nak");
    chk_eq("R3 no payload", tx_valid, 0);
    @(negedge clk);
    chk_eq("R3 single pulse", rsp_valid, 0);
  endtask

  task automatic t_normal_single();
    do_reset(0, 0, 0);
    fill(3, 'h10);
    do_commit();
    chk_eq("R7 full", buf_full, 1);
    chk_eq("R7 wr_ready low", wr_ready, 0);
    put_byte(8'hEE);
    do_commit();
    token(D0, 3, "R4 first send");
    recv(3, 'h10, 0, "R4 bytes");
    pulse_tmo();
    token(D0, 3, "R6 retry same pid");
    recv(3, 'h10, 0, "R6 retry bytes");
    pulse_ack();
    chk_eq("R6 released full", buf_full, 0);
    token(NAK, 0, "R6 released");
    fill(1, 'h20);
    do_commit();
    token(D1, 1, "R6 toggled");
    recv(1, 'h20, 0, "R6 next bytes");
    pulse_ack();
  endtask

  task automatic t_backpressure();
    do_reset(0, 0, 0);
    fill(5, 'h40);
    do_commit();
    token(D0, 5, "R4 stalled send");
    recv(5, 'h40, 1, "R4 stalled bytes");
    pulse_ack();
  endtask

  task automatic t_zlp();
    do_reset(0, 0, 0);
    do_commit();
    token(D0, 0, "R5 zlp");
    chk_eq("R5 no bytes", tx_valid, 0);
    @(negedge clk);
    chk_eq("R5 still no bytes", tx_valid, 0);
    pulse_ack();
    token(NAK, 0, "R5 zlp released");
  endtask

  task automatic t_double();
    do_reset(0, 0, 1);
    fill(2, 'h50);
    do_commit();
    chk_eq("R8 one slot not full", buf_full, 0);
    fill(3, 'h60);
    do_commit();
    chk_eq("R8 two slots full", buf_full, 1);
    token(D0, 2, "R8 first packet");
    recv(2, 'h50, 0, "R8 first bytes");
    pulse_ack();
    chk_eq("R8 room again", buf_full, 0);
    token(D1, 3, "R8 second packet");
    recv(3, 'h60, 0, "R8 second bytes");
    pulse_ack();
    token(NAK, 0, "R8 drained");
  endtask

  task automatic t_tgl();
    do_reset(0, 0, 0);
    fill(1, 'h70);
    do_commit();
    token(D0, 1, "R10 first");
    recv(1, 'h70, 0, "R10 first bytes");
    pulse_ack();
    @(negedge clk); tgl_clr = 1;
    @(negedge clk); tgl_clr = 0;
    fill(1, 'h71);
    do_commit();
    token(D0, 1, "R10 after clear");
    recv(1, 'h71, 0, "R10 bytes");
    pulse_ack();
  endtask

  task automatic t_ratefb();
    do_reset(0, 1, 1);
    fill(2, 'h80);
    do_commit();
    @(negedge clk);
    chk_eq("R9 not full", buf_full, 0);
    chk_eq("R9 wr_ready", wr_ready, 1);
    token(D0, 2, "R9 first");
    recv(2, 'h80, 0, "R9 first bytes");
    pulse_ack();
    token(D1, 2, "R9 repeat after ack");
    recv(2, 'h80, 0, "R9 repeat bytes");
    pulse_ack();
    token(D0, 2, "R9 third");
    recv(2, 'h80, 0, "R9 third bytes");
    pulse_tmo();
    token(D0, 2, "R9 after timeout");
    recv(2, 'h80, 0, "R9 timeout bytes");
    pulse_tmo();
    fill(1, 'h90);
    do_commit();
    @(negedge clk);
    token(D0, 1, "R9 replaced");
    recv(1, 'h90, 0, "R9 replaced bytes");
    pulse_ack();
    token(D1, 1, "R9 replacement kept");
    recv(1, 'h90, 0, "R9 replacement bytes");
    pulse_ack();
  endtask

  task automatic t_off();
    do_reset(1, 0, 0);
    fill(1, 'hA0);
    do_commit();
    token(NAK, 0, "R2 inactive nak");
    @(negedge clk); cfg_iso = 0;
    token(D0, 1, "R2 normal decode");
    recv(1, 'hA0, 0, "R2 bytes");
    pulse_ack();
  endtask

  task automatic t_ovf();
    do_reset(0, 0, 0);
    fill(MAXP + 2, 0);
    chk_eq("R11 ovf set", ovf, 1);
    do_commit();
    chk_eq("R11 ovf sticky", ovf, 1);
    token(D0, MAXP, "R11 saturated len");
    recv(MAXP, 0, 0, "R11 bytes");
    pulse_ack();
  endtask

  task automatic t_busy();
    do_reset(0, 0, 0);
    fill(2, 'hB0);
    do_commit();
    token(D0, 2, "R12 send");
    tok_in = 1;
    @(negedge clk); tok_in = 0;
    chk_eq("R12 busy token ignored", rsp_valid, 0);
    chk_eq("R4 stalled byte held", tx_data, 'hB0);
    recv(2, 'hB0, 0, "R12 bytes");
    pulse_ack();
    pulse_ack();
    fill(1, 'hC0);
    do_commit();
    pulse_ack();
    token(D1, 1, "R12 idle ack ignored");
    recv(1, 'hC0, 0, "R12 kept bytes");
    pulse_ack();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nak_empty();
    t_normal_single();
    t_backpressure();
    t_zlp();
    t_double();
    t_tgl();
    t_ratefb();
    t_off();
    t_ovf();
    t_busy();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule